// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block forms the address of the next control-store word in a microprogrammed control unit. It holds the control address register and a one-entry return register for microsubroutines. On every rising clock edge it loads the control address from one of several sources:

- the incremented address;
- a branch target carried in the current microinstruction;
- a microsubroutine call or return;
- a dispatch derived from the upper opcode bits of the instruction register;
- the interrupt or fetch vector taken at the end of each instruction.

The control store sits outside the block. Its output fields arrive as plain input buses, and the registered control address is sent back to it. A 3-bit sequencing code in the microinstruction chooses the source. A condition select field and an invert bit pick which status input a conditional step tests. The upper seven instruction bits drive the dispatch.

Top module: `useq_sequencer`

## Requirements
- R1: With sequencing code 0 (next), the control address becomes its current value plus one, wrapping from 0xFF to 0x00.
- R2: With code 1 (jump), the control address loads the branch target field.
- R3: With code 2 (conditional branch), the tested bit is cond_in[cond_sel] XOR cond_inv. When it is 1 the control address loads the branch target; otherwise it increments.
- R4: With code 3 (call), the return register loads the current control address plus one (wrapping), and the control address loads the branch target.
- R5: With code 4 (return), the control address loads the value held in the return register.
- R6: The return register keeps its value under every code except a call and a taken conditional call.
- R7: With code 5 (dispatch) and ir_top[6:5] not equal to 11, the control address becomes {1'b1, ir_top[6:0]}.
- R8: With code 5 and ir_top[6:5] = 11 (the branch instruction group), the control address becomes the branch-group entry 0x40.
- R9: With code 6 (end of instruction), the control address becomes the interrupt entry 0x10 if irq_pend is 1, and the fetch entry 0x00 otherwise.
- R10: With code 7 (conditional call), the block acts as a call (R4) when the tested bit of R3 is 1, and as a plain increment otherwise.
- R11: While rst_n is low, the control address is the fetch entry 0x00 and the return register is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| nac | input | 3 | Sequencing code from the microinstruction |
| cond_sel | input | 2 | Selects which cond_in bit is tested |
| cond_inv | input | 1 | Inverts the tested condition |
| br_addr | input | 8 | Branch or subroutine target from the microinstruction |
| cond_in | input | 4 | Status conditions from the datapath |
| ir_top | input | 7 | Instruction register bits 15 down to 9 |
| irq_pend | input | 1 | Interrupt request pending |
| car | output | 8 | Control address register |
| ret_addr | output | 8 | Microsubroutine return register |

## Verification
The embedded properties assume that every input holds a known value at each rising edge while reset is released. They also assume that the return register is read only after a call has filled it, although a return from the reset value is still well defined. The bench drives each input at the falling edge, so all inputs are stable and known at every rising edge. The stimulus covers every sequencing code, both invert settings, all four dispatch groups and both interrupt states. It also asserts reset in the middle of a run. A behavioural reference model in the bench predicts both registers for every cycle.

// File: rtl/useq_sequencer.sv
module useq_sequencer #(
  parameter int AW = 8,
  parameter int CW = 4,
  parameter logic [AW-1:0] FETCH_ENTRY  = 8'h00,
  parameter logic [AW-1:0] INT_ENTRY    = 8'h10,
  parameter logic [AW-1:0] BRANCH_ENTRY = 8'h40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            nac,
  input  logic [$clog2(CW)-1:0] cond_sel,
  input  logic                  cond_inv,
  input  logic [AW-1:0]         br_addr,
  input  logic [CW-1:0]         cond_in,
  input  logic [AW-2:0]         ir_top,
  input  logic                  irq_pend,
  output logic [AW-1:0]         car,
  output logic [AW-1:0]         ret_addr
);
  localparam logic [2:0] C_NEXT = 3'd0, C_JUMP = 3'd1, C_CBR  = 3'd2, C_CALL = 3'd3,
                         C_RET  = 3'd4, C_DISP = 3'd5, C_END  = 3'd6, C_CCAL = 3'd7;
  localparam logic [AW-1:0] ONE = AW'(1);

  logic          cond_ok;
  logic [1:0]    grp;
  logic [AW-1:0] car_inc, disp_addr, car_d, ret_d;

  assign cond_ok   = cond_in[cond_sel] ^ cond_inv;
  assign car_inc   = car + ONE;
  assign grp       = ir_top[AW-2 -: 2];
  assign disp_addr = (grp == 2'b11) ? BRANCH_ENTRY : {1'b1, ir_top};

  always_comb begin
    car_d = car_inc;
    ret_d = ret_addr;
    case (nac)
      C_JUMP: car_d = br_addr;
      C_CBR:  if (cond_ok) car_d = br_addr;
      C_CALL: begin car_d = br_addr; ret_d = car_inc; end
      C_RET:  car_d = ret_addr;
      C_DISP: car_d = disp_addr;
      C_END:  car_d = irq_pend ? INT_ENTRY : FETCH_ENTRY;
      C_CCAL: if (cond_ok) begin car_d = br_addr; ret_d = car_inc; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car      <= FETCH_ENTRY;
      ret_addr <= '0;
    end else begin
      car      <= car_d;
      ret_addr <= ret_d;
    end
  end

  AST_NEXT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    nac == C_NEXT |=> car == AW'($past(car) + ONE)); // R1
  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    nac == C_JUMP |=> car == $past(br_addr)); // R2
  AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    nac == C_CALL |=> ret_addr == AW'($past(car) + ONE) && car == $past(br_addr)); // R4
  AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    nac == C_RET |=> car == $past(ret_addr)); // R5
  AST_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    nac != C_CALL && nac != C_CCAL |=> $stable(ret_addr)); // R6
  AST_BRANCH_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    nac == C_DISP && ir_top[AW-2 -: 2] == 2'b11 |=> car == BRANCH_ENTRY); // R8
  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    nac == C_END && irq_pend |=> car == INT_ENTRY); // R9
  AST_FETCH_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    nac == C_END && !irq_pend |=> car == FETCH_ENTRY); // R9
endmodule

// File: tb/useq_sequencer_test.sv
`timescale 1ns/1ps
module useq_sequencer_test;
  logic       clk = 0, rst_n = 0;
  logic [2:0] nac = 0;
  logic [1:0] cond_sel = 0;
  logic       cond_inv = 0;
  logic [7:0] br_addr = 0;
  logic [3:0] cond_in = 0;
  logic [6:0] ir_top = 0;
  logic       irq_pend = 0;
  logic [7:0] car, ret_addr;

  int n_chk = 0, n_fail = 0;
  int m_car = 0, m_ret = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  useq_sequencer uut (.clk(clk), .rst_n(rst_n), .nac(nac), .cond_sel(cond_sel),
    .cond_inv(cond_inv), .br_addr(br_addr), .cond_in(cond_in), .ir_top(ir_top),
    .irq_pend(irq_pend), .car(car), .ret_addr(ret_addr));

  function automatic string tag_of(int code, int grp);
    case (code)
      0: return "R1";  1: return "R2";  2: return "R3";  3: return "R4";
      4: return "R5";  5: return (grp == 3) ? "R8" : "R7";
      6: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic compare(string tag);
    n_chk++;
    if (car !== 8'(m_car)) begin
      n_fail++;
      $display("FAIL %s car actual %h expected %h", tag, car, 8'(m_car));
    end
    n_chk++;
    if (ret_addr !== 8'(m_ret)) begin
      n_fail++;
      $display("FAIL %s/R6 ret_addr actual %h expected %h", tag, ret_addr, 8'(m_ret));
    end
  endtask

  task automatic step(int code, int sel, int inv, int br, int conds, int ir, int irq);
    int c;
    nac = 3'(code); cond_sel = 2'(sel); cond_inv = inv[0]; br_addr = 8'(br);
    cond_in = 4'(conds); ir_top = 7'(ir); irq_pend = irq[0];
    c = ((conds >> sel) & 1) ^ (inv & 1);
    case (code)
      0: m_car = (m_car + 1) % 256;
      1: m_car = br;
      2: m_car = c ? br : (m_car + 1) % 256;
      3: begin m_ret = (m_car + 1) % 256; m_car = br; end
      4: m_car = m_ret;
      5: m_car = ((ir >> 5) == 3) ? 64 : 128 + ir;
      6: m_car = irq ? 16 : 0;
      default: if (c) begin m_ret = (m_car + 1) % 256; m_car = br; end
               else m_car = (m_car + 1) % 256;
    endcase
    @(posedge clk); @(negedge clk);
    compare(tag_of(code, ir >> 5));
  endtask

  task automatic do_reset();
    rst_n = 0; m_car = 0; m_ret = 0;
    @(negedge clk);
    compare("R11");
    rst_n = 1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    step(1, 0, 0, 8'hFE, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);          // R1 wrap to 00
    step(2, 2, 0, 8'h33, 4'b0100, 0, 0); // R3 taken
    step(2, 2, 1, 8'h77, 4'b0100, 0, 0); // R3 inverted, not taken
    step(2, 1, 1, 8'h55, 4'b0000, 0, 0); // R3 inverted, taken
    step(3, 0, 0, 8'hA0, 0, 0, 0);       // R4
    step(0, 0, 0, 0, 0, 0, 0);
    step(4, 0, 0, 0, 0, 0, 0);           // R5
    step(1, 0, 0, 8'hFF, 0, 0, 0);
    step(3, 0, 0, 8'h20, 0, 0, 0);       // R4 wrap of link
    step(7, 3, 0, 8'h90, 4'b0000, 0, 0); // R10 not taken
    step(7, 3, 0, 8'h90, 4'b1000, 0, 0); // R10 taken
    step(4, 0, 0, 0, 0, 0, 0);
    for (int g = 0; g < 4; g++) step(5, 0, 0, 0, 0, g * 32 + 5 + g, 0); // R7 R8
    step(6, 0, 0, 0, 0, 0, 1);           // R9 interrupt
    step(6, 0, 0, 0, 0, 0, 0);           // R9 fetch
    for (int i = 0; i < 3000; i++) begin
      if (i == 1500) do_reset();
      step($urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 1),
           $urandom_range(0, 255), $urandom_range(0, 15), $urandom_range(0, 127),
           $urandom_range(0, 1));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule